// File: doc/BRIEF.md
# Sampling-Point Tuning Search Engine

This block is a hardware sequencer that picks the receive sampling tap for an HS200 link. On a start request it walks the tap setting upward from 0 to the last tap. For each tap it asks the delay line to take the new value, waits for the update to be acknowledged, then asks the transfer logic to run one tuning-block read and waits for the pass/fail verdict. A tap counts as failed if its verdict is a fail, or if its update is not acknowledged within a bounded number of cycles.

While it sweeps, the engine keeps a running count of consecutive passing taps. It also keeps the longest such run seen so far and the tap where that run ended. After the last tap it programs the centre of the longest run and pulses done. If no tap passed, it raises an error with done and leaves the tap setting alone. When the link is not in HS200 mode, a start does nothing except pulse done, so that a different tuning method can take over.

States: `ST_IDLE` (waiting for start), `ST_APPLY` (tap update requested), `ST_XFER` (tuning transfer requested), `ST_NEXT` (step or decide), `ST_SETTLE` (final tap update requested), `ST_FINISH` (done pulse) and `ST_FAIL` (done pulse with error). Transitions:
- IDLE→APPLY on start in HS200.
- IDLE→FINISH on start outside HS200.
- APPLY→XFER on update acknowledge.
- APPLY→NEXT on timeout.
- XFER→NEXT on verdict.
- NEXT→APPLY while taps remain.
- NEXT→SETTLE after the last tap when a pass was seen.
- NEXT→FAIL after the last tap when no tap passed.
- SETTLE→FINISH on acknowledge or timeout.
- FINISH→IDLE and FAIL→IDLE unconditionally.

Top module: `tune_search`

## Requirements
- R1: After reset, tap_o is 0 and upd_req_o, xfer_req_o, done_o and err_o are all low.
- R2: In HS200 mode, taps are visited in increasing order 0 to 39. Each tap gets an update request, and after its acknowledge one transfer request, so a fully acknowledged sweep issues exactly 40 transfer requests.
- R3: A failing tap clears the running streak, so passes separated by a single failure never merge into one window.
- R4: A window replaces the stored best only when it is strictly longer; of two equally long windows the earlier one wins.
- R5: After a sweep with at least one pass, tap_o is set to (end of best window) − floor(length/2). One extra update request (41 in total) is issued for it, and done_o follows.
- R6: If no tap passes, err_o goes high together with done_o, no extra update request is issued (40 in total), and err_o is cleared by the next accepted start.
- R7: A start with hs200_i low yields a done_o pulse with no update or transfer request, err_o low and tap_o unchanged.
- R8: An update request not acknowledged within TMO_CYC cycles marks that tap failed and skips its transfer request; the sweep continues.
- R9: done_o is high for exactly one cycle per accepted start.
- R10: start_i asserted while a search is running has no effect.
- R11: upd_req_o and xfer_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a search (taken only when idle) |
| hs200_i | input | 1 | High when the link runs in HS200 mode |
| upd_done_i | input | 1 | Acknowledge of the tap update request |
| res_valid_i | input | 1 | Tuning transfer verdict strobe |
| res_pass_i | input | 1 | Verdict: 1 = pass, 0 = fail |
| tap_o | output | 6 | Current sampling tap |
| upd_req_o | output | 1 | Request to load tap_o into the delay line |
| xfer_req_o | output | 1 | Request for a tuning-block transfer, held until the verdict |
| done_o | output | 1 | One-cycle end-of-search pulse |
| err_o | output | 1 | No passing tap found; held until next start |

## Verification
The hardest situations to reach are those where the window bookkeeping could go wrong without changing the obvious outcome. These are a tie between two equal windows, passes split by a lone failure, and a window broken only by updates that are never acknowledged. The bench uses a reactive responder for the delay line and the transfer logic. It drives each verdict from a per-tap pass mask and withholds the acknowledge for taps named in a separate mask. Each pattern is then chosen so that a wrong tie rule, a missing streak reset or a lost timeout moves the final tap to a different value. A second start is also injected mid-sweep, and the test checks that the request counts and the single done pulse stay unchanged.

// File: rtl/tune_pkg.sv
package tune_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APPLY,
        ST_XFER,
        ST_NEXT,
        ST_SETTLE,
        ST_FINISH,
        ST_FAIL
    } tune_state_e;
endpackage

// File: rtl/tune_timer.sv
module tune_timer #(
    parameter int TMO_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CW'(TMO_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TMO_CYC - 1));
endmodule

// File: rtl/tune_streak.sv
module tune_streak #(
    parameter int NUM_TAPS = 40,
    parameter int TAP_W    = 6,
    parameter int LEN_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rec,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic [LEN_W-1:0] best_len,
    output logic [TAP_W-1:0] best_end
);
    logic [LEN_W-1:0] cur_q;
    logic [LEN_W-1:0] cur_inc;

    assign cur_inc = cur_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            best_len <= '0;
            best_end <= '0;
        end else if (clr) begin
            cur_q    <= '0;
            best_len <= '0;
            best_end <= '0;
        end else if (rec) begin
            if (pass) begin
                cur_q <= cur_inc;
                if (cur_inc > best_len) begin
                    best_len <= cur_inc;
                    best_end <= tap;
                end
            end else begin
                cur_q <= '0;
            end
        end
    end

    // R4
    best_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= best_len);

    // R4
    best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> best_len >= $past(best_len));

    // R3
    streak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec && !pass && !clr) |=> cur_q == '0);
endmodule

// File: rtl/tune_search.sv
module tune_search
    import tune_pkg::*;
#(
    parameter int NUM_TAPS = 40,
    parameter int TMO_CYC  = 16,
    parameter int TAP_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             hs200_i,
    input  logic             upd_done_i,
    input  logic             res_valid_i,
    input  logic             res_pass_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             upd_req_o,
    output logic             xfer_req_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int LEN_W = $clog2(NUM_TAPS + 1);
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

    tune_state_e      state_q, state_d;
    logic [TAP_W-1:0] tap_q;
    logic             err_q;
    logic             tmo;
    logic             accept;
    logic             rec;
    logic             pass;
    logic [LEN_W-1:0] best_len;
    logic [TAP_W-1:0] best_end;
    logic [TAP_W-1:0] centre;
    logic             at_last;

    assign accept  = (state_q == ST_IDLE) && start_i;
    assign at_last = (tap_q == LAST_TAP);
    assign rec     = ((state_q == ST_APPLY) && !upd_done_i && tmo)
                   || ((state_q == ST_XFER) && res_valid_i);
    assign pass    = (state_q == ST_XFER) && res_pass_i;
    assign centre  = best_end - TAP_W'(best_len >> 1);

    tune_timer #(.TMO_CYC(TMO_CYC)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (upd_req_o),
        .expired (tmo)
    );

    tune_streak #(.NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W), .LEN_W(LEN_W)) i_streak (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .rec      (rec),
        .pass     (pass),
        .tap      (tap_q),
        .best_len (best_len),
        .best_end (best_end)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = hs200_i ? ST_APPLY : ST_FINISH;
            ST_APPLY:  if (upd_done_i) state_d = ST_XFER;
                       else if (tmo) state_d = ST_NEXT;
            ST_XFER:   if (res_valid_i) state_d = ST_NEXT;
            ST_NEXT:   if (!at_last) state_d = ST_APPLY;
                       else state_d = (best_len == '0) ? ST_FAIL : ST_SETTLE;
            ST_SETTLE: if (upd_done_i || tmo) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            ST_FAIL:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tap_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                err_q <= 1'b0;
                if (hs200_i) tap_q <= '0;
            end
            if (state_q == ST_NEXT) begin
                if (!at_last)
                    tap_q <= tap_q + 1'b1;
                else if (best_len != '0)
                    tap_q <= centre;
                else
                    err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        tap_o      = tap_q;
        err_o      = err_q;
        upd_req_o  = (state_q == ST_APPLY) || (state_q == ST_SETTLE);
        xfer_req_o = (state_q == ST_XFER);
        done_o     = (state_q == ST_FINISH) || (state_q == ST_FAIL);
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_req_o && xfer_req_o));

    // R2
    tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_o <= LAST_TAP);

    // R6
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

    // R10
    busy_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !res_valid_i) |=> $stable(tap_o));
endmodule

// File: tb/test_tune_search.sv
module test_tune_search;
    localparam int NT = 40;

    typedef struct packed {
        logic [NT-1:0] pass;
        logic [NT-1:0] noack;
        logic          hs;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{40'hFF_FFFF_FFFF, 40'h0, 1'b1},            // full window
        '{40'h00_000F_FC00, 40'h0, 1'b1},            // 10..19
        '{40'h00_01F0_007C, 40'h0, 1'b1},            // tie 2..6 / 20..24
        '{40'h0F_C000_0007, 40'h0, 1'b1},            // later longer
        '{40'h00_0000_0000, 40'h0, 1'b1},            // none
        '{40'h80_0000_0000, 40'h0, 1'b1},            // only last
        '{40'hFF_FFFF_FFFF, 40'h00_000F_8000, 1'b1}, // timeouts split
        '{40'h00_0000_0001, 40'h0, 1'b1},            // only first
        '{40'h00_0000_0FE0, 40'h0, 1'b1},            // 5..11
        '{40'h00_0000_0077, 40'h0, 1'b1},            // lone fail split
        '{40'hFF_FFFF_FFFF, 40'h0, 1'b0}             // not HS200
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       hs200_i = 1'b0;
    logic       upd_done_i = 1'b0;
    logic       res_valid_i = 1'b0;
    logic       res_pass_i = 1'b0;
    logic [5:0] tap_o;
    logic       upd_req_o, xfer_req_o, done_o, err_o;

    int checks = 0;
    int errors = 0;
    int n_xfer = 0;
    int n_upd = 0;
    int n_done = 0;
    int overlap = 0;
    logic upd_prev = 1'b0;
    logic [NT-1:0] m_pass = '0;
    logic [NT-1:0] m_noack = '0;
    longint cyc = 0;

    always #10 clk = ~clk;

    tune_search i_tune_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hs200_i(hs200_i),
        .upd_done_i(upd_done_i), .res_valid_i(res_valid_i), .res_pass_i(res_pass_i),
        .tap_o(tap_o), .upd_req_o(upd_req_o), .xfer_req_o(xfer_req_o),
        .done_o(done_o), .err_o(err_o)
    );

    // Responder and monitor, active on the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (upd_req_o && !upd_prev) n_upd = n_upd + 1;
        upd_prev = upd_req_o;
        if (done_o) n_done = n_done + 1;
        if (upd_req_o && xfer_req_o) overlap = overlap + 1;
        upd_done_i = upd_req_o && !upd_done_i && !m_noack[tap_o];
        res_valid_i = xfer_req_o && !res_valid_i;
        res_pass_i = m_pass[tap_o];
        if (res_valid_i) n_xfer = n_xfer + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void ref_search(input logic [NT-1:0] p, input logic [NT-1:0] na,
                                       output int tap, output int err);
        int cur = 0;
        int best = 0;
        int bend = 0;
        for (int i = 0; i < NT; i++) begin
            if (p[i] && !na[i]) begin
                cur++;
                if (cur > best) begin best = cur; bend = i; end
            end else cur = 0;
        end
        err = (best == 0);
        tap = bend - best / 2;
    endfunction

    task automatic run_case(input vec_t v, input bit busy_start);
        int etap, eerr, prev_tap, na_cnt, waited;
        ref_search(v.pass, v.noack, etap, eerr);
        na_cnt = $countones(v.noack);
        prev_tap = tap_o;
        @(negedge clk);
        m_pass = v.pass; m_noack = v.noack; hs200_i = v.hs;
        n_xfer = 0; n_upd = 0; n_done = 0; overlap = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (busy_start) begin
            repeat (30) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        if (!v.hs) begin
            check("R7 tap", tap_o, prev_tap);
            check("R7 err", err_o, 0);
        end else if (eerr) begin
            check("R6 err", err_o, 1);
        end else begin
            check("R5 R3 R4 tap", tap_o, etap);
            check("R5 err", err_o, 0);
        end
        repeat (4) @(negedge clk);
        check("R9 done pulses", n_done, 1);
        check("R11 overlap", overlap, 0);
        if (!v.hs) begin
            check("R7 upd", n_upd, 0);
            check("R7 xfer", n_xfer, 0);
        end else begin
            check("R2 R8 xfer", n_xfer, NT - na_cnt);
            check("R5 R6 upd", n_upd, eerr ? NT : NT + 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tap", tap_o, 0);
        check("R1 upd", upd_req_o, 0);
        check("R1 xfer", xfer_req_o, 0);
        check("R1 done", done_o, 0);
        check("R1 err", err_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < NV; k++) run_case(VECS[k], 1'b0);
        // R6: err clears on the next accepted start
        run_case(VECS[4], 1'b0);
        run_case(VECS[10], 1'b0);
        check("R6 err cleared", err_o, 0);
        // R10: second start mid-sweep is ignored
        run_case(VECS[1], 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule